// File: doc/BRIEF.md
# Two-Point Per-Pixel Line Corrector

This block removes fixed-pattern non-uniformity from the pixel stream of a push-broom line sensor. Every pixel position along a line owns a gain and an offset. A raw sample first has its offset subtracted. The difference is then multiplied by the gain and rounded back to the pixel width. Pixels arrive one per valid cycle, and a line-start flag marks the first pixel of each line. The block derives each pixel's position itself: it counts valid pixels from the line start and wraps at a programmed line length.

The coefficient table lives in on-chip registers and can be rewritten through a load port at any time, for example to replace factors that have drifted in service. A write only reaches the table in use at the next line start, so no line is ever corrected with a mix of old and new factors. A mode input selects raw pass-through for calibration imaging. Samples at the converter's full-scale code are treated as clipped and pass through unchanged, so saturated pixels cannot turn into false grey levels.

Top module: `nuc_corrector`

## Requirements
- R1: In correction mode (`mode_cal`=0), an unsaturated pixel at position p is output as floor(((raw − off[p]) × gain[p] + 8192) / 2^14). Gain is an unsigned 16-bit value in which 16384 means unity, and off is a signed 13-bit two's-complement value.
- R2: A corrected result below 0 is output as 0, and a result above 4095 is output as 4095.
- R3: In correction mode, a raw sample equal to 4095 is output as 4095 whatever coefficients apply to its position.
- R4: While `mode_cal`=1 at the cycle a pixel is presented, that pixel is output exactly as received.
- R5: A pixel presented in cycle n appears in cycle n+3. `out_valid` and `out_sol` repeat `in_valid` and `in_valid & in_sol` with the same 3-cycle delay.
- R6: A pixel with `in_sol`=1 uses position 0. Each following valid pixel takes the next position, and the position after line_len−1 is 0. Cycles with `in_valid`=0 do not advance the position.
- R7: A coefficient write is applied to the table in use at the next valid line-start pixel, and that pixel already uses it. A write in the same cycle as a line start takes effect at the following line start.
- R8: After reset, all outputs are 0, and every position holds gain 16384 and offset 0, so a corrected line equals the raw line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A raw pixel is present |
| in_sol | input | 1 | The present pixel is the first of a line |
| in_pix | input | 12 | Raw pixel value |
| mode_cal | input | 1 | 1 = calibration pass-through, 0 = corrected output |
| line_len | input | LEN_W (7) | Number of pixels per line, 1..DEPTH |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | IDX_W (6) | Pixel position to write |
| cw_gain | input | 16 | New gain, unsigned, 16384 = unity |
| cw_off | input | 13 | New offset, signed |
| out_valid | output | 1 | Output pixel is present |
| out_sol | output | 1 | Output pixel starts a line |
| out_pix | output | 12 | Corrected or passed-through pixel |

## Verification
Some rules hold on every cycle, and the assertions check those continuously. The output flags lag the input flags by exactly three cycles. A clipped or calibration-mode pixel leaves the last stage carrying its raw value. The table in use never changes except at a line-start pixel. Idle cycles leave the position counter untouched. The bench's scenarios are needed to show the arithmetic itself: the rounding, the clamping at both ends, and the exact line on which a reloaded factor first appears, including a write that lands on a line-start cycle. They also show position wrap-around on an overlong line and the unity table after reset.

// File: rtl/nuc_pkg.sv
package nuc_pkg;

    localparam int PIX_W      = 12;
    localparam int GAIN_W     = 16;
    localparam int GAIN_FRAC  = 14;
    localparam int OFF_W      = 13;
    localparam int PROD_W     = 32;
    localparam int PIX_MAX    = (1 << PIX_W) - 1;
    localparam int GAIN_ONE   = 1 << GAIN_FRAC;
    localparam int ROUND_HALF = 1 << (GAIN_FRAC - 1);

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic [GAIN_W-1:0]        gain_t;
    typedef logic signed [OFF_W-1:0]  off_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    typedef enum logic {
        MODE_CORRECT = 1'b0,
        MODE_CAL     = 1'b1
    } mode_e;

    typedef struct packed {
        logic  valid;
        logic  sol;
        mode_e mode;
        logic  sat;
        pix_t  raw;
        gain_t gain;
        off_t  off;
    } fetch_t;

    typedef struct packed {
        logic  valid;
        logic  sol;
        mode_e mode;
        logic  sat;
        pix_t  raw;
        prod_t prod;
    } mult_t;

    function automatic pix_t round_clamp(input prod_t p);
        prod_t r;
        r = (p + prod_t'(ROUND_HALF)) >>> GAIN_FRAC;
        if (r < 0)
            return '0;
        else if (r > prod_t'(PIX_MAX))
            return pix_t'(PIX_MAX);
        else
            return r[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/nuc_line_addr.sv
module nuc_line_addr #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic [LEN_W-1:0] line_len,
    output logic [IDX_W-1:0] addr,
    output logic             commit
);

    logic [IDX_W-1:0] cnt;
    logic [LEN_W-1:0] nxt;

    always_comb begin
        addr   = in_sol ? '0 : cnt;
        commit = in_valid && in_sol;
        nxt    = LEN_W'(addr) + LEN_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (in_valid) begin
            if (nxt == line_len)
                cnt <= '0;
            else
                cnt <= nxt[IDX_W-1:0];
        end
    end

    // R6: idle cycles leave the position untouched
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(cnt));

endmodule

// File: rtl/nuc_coef_bank.sv
module nuc_coef_bank
    import nuc_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  gain_t            wr_gain,
    input  off_t             wr_off,
    input  logic             commit,
    input  logic [IDX_W-1:0] rd_addr,
    output gain_t            rd_gain,
    output off_t             rd_off
);

    gain_t [DEPTH-1:0] stg_gain;
    off_t  [DEPTH-1:0] stg_off;
    gain_t [DEPTH-1:0] act_gain;
    off_t  [DEPTH-1:0] act_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                stg_gain[i] <= gain_t'(GAIN_ONE);
                stg_off[i]  <= '0;
                act_gain[i] <= gain_t'(GAIN_ONE);
                act_off[i]  <= '0;
            end
        end else begin
            if (commit) begin
                act_gain <= stg_gain;
                act_off  <= stg_off;
            end
            if (wr_en) begin
                stg_gain[wr_addr] <= wr_gain;
                stg_off[wr_addr]  <= wr_off;
            end
        end
    end

    // The line-start pixel already sees the staged table it commits.
    always_comb begin
        if (commit) begin
            rd_gain = stg_gain[rd_addr];
            rd_off  = stg_off[rd_addr];
        end else begin
            rd_gain = act_gain[rd_addr];
            rd_off  = act_off[rd_addr];
        end
    end

    // R7: the table in use is frozen between line starts
    assert_active_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(act_gain) && $stable(act_off)));

endmodule

// File: rtl/nuc_datapath.sv
module nuc_datapath
    import nuc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_sol,
    input  mode_e in_mode,
    input  pix_t  in_pix,
    input  gain_t in_gain,
    input  off_t  in_off,
    output logic  out_valid,
    output logic  out_sol,
    output pix_t  out_pix
);

    fetch_t s1;
    mult_t  s2;
    prod_t  diff_x;
    prod_t  gain_x;

    // Stage 1: capture pixel with its coefficients
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            s1.sol   <= in_valid && in_sol;
            s1.mode  <= in_mode;
            s1.sat   <= (in_pix == pix_t'(PIX_MAX));
            s1.raw   <= in_pix;
            s1.gain  <= in_gain;
            s1.off   <= in_off;
        end
    end

    always_comb begin
        diff_x = prod_t'({1'b0, s1.raw}) - prod_t'($signed(s1.off));
        gain_x = prod_t'({1'b0, s1.gain});
    end

    // Stage 2: offset-removed difference times gain
    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.valid <= s1.valid;
            s2.sol   <= s1.sol;
            s2.mode  <= s1.mode;
            s2.sat   <= s1.sat;
            s2.raw   <= s1.raw;
            s2.prod  <= diff_x * gain_x;
        end
    end

    // Stage 3: round, clamp and select
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s2.valid;
            out_sol   <= s2.sol;
            if (s2.mode == MODE_CAL || s2.sat)
                out_pix <= s2.raw;
            else
                out_pix <= round_clamp(s2.prod);
        end
    end

    // R3: a clipped sample leaves the pipe at full scale
    assert_sat_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (s2.valid && s2.sat && s2.mode == MODE_CORRECT) |=> out_pix == pix_t'(PIX_MAX));

    // R4: calibration pixels leave the pipe untouched
    assert_cal_raw_R4: assert property (@(posedge clk) disable iff (rst)
        (s2.valid && s2.mode == MODE_CAL) |=> out_pix == $past(s2.raw));

    // R5: a line start is always a valid pixel
    assert_sol_valid_R5: assert property (@(posedge clk) disable iff (rst)
        out_sol |-> out_valid);

endmodule

// File: rtl/nuc_corrector.sv
module nuc_corrector
    import nuc_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_sol,
    input  logic [PIX_W-1:0]     in_pix,
    input  logic                 mode_cal,
    input  logic [LEN_W-1:0]     line_len,
    input  logic                 cw_en,
    input  logic [IDX_W-1:0]     cw_addr,
    input  logic [GAIN_W-1:0]    cw_gain,
    input  logic [OFF_W-1:0]     cw_off,
    output logic                 out_valid,
    output logic                 out_sol,
    output logic [PIX_W-1:0]     out_pix
);

    logic [IDX_W-1:0] addr;
    logic             commit;
    gain_t            rd_gain;
    off_t             rd_off;
    mode_e            mode;

    assign mode = mode_cal ? MODE_CAL : MODE_CORRECT;

    nuc_line_addr #(.DEPTH(DEPTH)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .line_len (line_len),
        .addr     (addr),
        .commit   (commit)
    );

    nuc_coef_bank #(.DEPTH(DEPTH)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cw_en),
        .wr_addr (cw_addr),
        .wr_gain (cw_gain),
        .wr_off  (off_t'(cw_off)),
        .commit  (commit),
        .rd_addr (addr),
        .rd_gain (rd_gain),
        .rd_off  (rd_off)
    );

    nuc_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sol    (in_sol),
        .in_mode   (mode),
        .in_pix    (in_pix),
        .in_gain   (rd_gain),
        .in_off    (rd_off),
        .out_valid (out_valid),
        .out_sol   (out_sol),
        .out_pix   (out_pix)
    );

    // Cycles since reset, saturating, so the latency check never looks into reset.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)
            age <= '0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    // R5: flags appear three cycles after they are presented
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3) &&
                           out_sol == $past(in_valid && in_sol, 3)));

endmodule

// File: tb/sim_nuc_corrector.sv
module sim_nuc_corrector;

    localparam int DEPTH = 64;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int LEN_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_sol = 1'b0;
    logic [11:0]      in_pix = '0;
    logic             mode_cal = 1'b0;
    logic [LEN_W-1:0] line_len = LEN_W'(16);
    logic             cw_en = 1'b0;
    logic [IDX_W-1:0] cw_addr = '0;
    logic [15:0]      cw_gain = '0;
    logic [12:0]      cw_off = '0;
    logic             out_valid;
    logic             out_sol;
    logic [11:0]      out_pix;

    always #4 clk = ~clk;   // 125 MHz

    nuc_corrector #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol), .in_pix(in_pix),
        .mode_cal(mode_cal), .line_len(line_len), .cw_en(cw_en), .cw_addr(cw_addr),
        .cw_gain(cw_gain), .cw_off(cw_off), .out_valid(out_valid), .out_sol(out_sol),
        .out_pix(out_pix)
    );

    int    compared = 0;
    int    mismatched = 0;
    string phase = "R8";
    int    seed = 12345;

    // ---------------- reference model ----------------
    typedef struct {
        bit    v;
        bit    s;
        int    pix;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   m_stg_g[DEPTH];
    int   m_stg_o[DEPTH];
    int   m_act_g[DEPTH];
    int   m_act_o[DEPTH];
    int   m_cnt = 0;

    always @(posedge clk) begin
        exp_t e;
        int   a;
        int   g;
        int   o;
        int   r;
        if (rst) begin
            exp_q.delete();
            m_cnt = 0;
            for (int i = 0; i < DEPTH; i++) begin
                m_stg_g[i] = 16384; m_stg_o[i] = 0;
                m_act_g[i] = 16384; m_act_o[i] = 0;
            end
        end else begin
            a = in_sol ? 0 : m_cnt;
            g = (in_valid && in_sol) ? m_stg_g[a] : m_act_g[a];
            o = (in_valid && in_sol) ? m_stg_o[a] : m_act_o[a];
            e.v = in_valid;
            e.s = in_valid && in_sol;
            e.tag = phase;
            if (mode_cal) begin
                e.pix = in_pix; e.tag = {phase, "/R4"};
            end else if (in_pix == 4095) begin
                e.pix = 4095; e.tag = {phase, "/R3"};
            end else begin
                r = ((int'(in_pix) - o) * g + 8192) >>> 14;
                e.tag = {phase, "/R1"};
                if (r < 0) begin r = 0; e.tag = {phase, "/R2"}; end
                if (r > 4095) begin r = 4095; e.tag = {phase, "/R2"}; end
                e.pix = r;
            end
            if (in_valid && in_sol)
                for (int i = 0; i < DEPTH; i++) begin
                    m_act_g[i] = m_stg_g[i]; m_act_o[i] = m_stg_o[i];
                end
            if (cw_en) begin
                m_stg_g[cw_addr] = cw_gain;
                m_stg_o[cw_addr] = $signed(cw_off);
            end
            if (in_valid)
                m_cnt = ((a + 1) == int'(line_len)) ? 0 : (a + 1) % DEPTH;
            exp_q.push_back(e);
            if (exp_q.size() > 3) void'(exp_q.pop_front());
        end
    end

    // ---------------- comparison, away from the active edge ----------------
    always @(negedge clk) begin
        if (rst) begin
            compared++;
            if (out_valid !== 1'b0 || out_sol !== 1'b0 || out_pix !== 12'd0) begin
                mismatched++;
                $display("FAIL R8 reset outputs: valid=%0b sol=%0b pix=%0d expected 0/0/0",
                         out_valid, out_sol, out_pix);
            end
        end else if (exp_q.size() == 3) begin
            compared++;
            if (out_valid !== exp_q[0].v || out_sol !== exp_q[0].s) begin
                mismatched++;
                $display("FAIL R5 [%s] flags: valid=%0b sol=%0b expected %0b/%0b",
                         exp_q[0].tag, out_valid, out_sol, exp_q[0].v, exp_q[0].s);
            end else if (exp_q[0].v && int'(out_pix) != exp_q[0].pix) begin
                mismatched++;
                $display("FAIL [%s] pixel: got %0d expected %0d",
                         exp_q[0].tag, out_pix, exp_q[0].pix);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic int rnd(input int range);
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return (seed >>> 8) % range;
    endfunction

    task automatic step(input bit v, input bit s, input int pix,
                        input bit we = 0, input int wa = 0, input int wg = 0, input int wo = 0);
        @(negedge clk);
        in_valid = v;
        in_sol   = s;
        in_pix   = 12'(pix);
        cw_en    = we;
        cw_addr  = IDX_W'(wa);
        cw_gain  = 16'(wg);
        cw_off   = 13'(wo);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    task automatic line_ramp(input int n, input int base, input int stp);
        for (int i = 0; i < n; i++) step(1, i == 0, (base + i * stp) % 4096);
    endtask

    task automatic line_rand(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && rnd(3) == 0) step(0, 0, rnd(4096));
            step(1, i == 0, (rnd(8) == 0) ? 4095 : rnd(4096));
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R8: unity table after reset, including a clipped sample
        phase = "R8";
        line_ramp(16, 0, 250);
        step(1, 1, 4095);
        line_ramp(15, 17, 271);
        idle(4);

        // R1/R2: load distinct factors, including clamp-provoking ones
        phase = "R1";
        for (int i = 0; i < 16; i++)
            step(0, 0, 0, 1, i, 8192 + rnd(32768), rnd(601) - 300);
        step(0, 0, 0, 1, 3, 16384, 4000);   // strong positive offset -> low clamp
        step(0, 0, 0, 1, 5, 65535, -4096);  // maximal gain -> high clamp
        step(0, 0, 0, 1, 6, 0, 0);          // zero gain -> 0
        idle(2);
        for (int k = 0; k < 3; k++) line_rand(16, 0);
        line_ramp(16, 100, 255);
        idle(3);

        // R7: mid-line write waits for the next line start
        phase = "R7";
        for (int i = 0; i < 16; i++)
            if (i == 2) step(1, 0, 1000 + i, 1, 10, 30000, 200);
            else step(1, i == 0, 1000 + i * 50);
        line_ramp(16, 1000, 50);
        // write on a line-start cycle defers one more line
        step(1, 1, 2000, 1, 0, 9000, -100);
        for (int i = 1; i < 16; i++) step(1, 0, 2000 + i);
        line_ramp(16, 2000, 1);
        idle(3);

        // R6: gaps in valid and wrap on an overlong line
        phase = "R6";
        line_rand(16, 1);
        line_rand(40, 0);         // one start, positions wrap past 15
        line_len = LEN_W'(5);
        line_rand(12, 1);
        for (int i = 0; i < 7; i++) step(1, i == 0 || i == 3, rnd(4096)); // restart mid-line
        line_len = LEN_W'(16);
        idle(3);

        // R4: calibration pass-through
        phase = "R4";
        mode_cal = 1'b1;
        line_rand(16, 1);
        line_ramp(16, 3900, 13);
        mode_cal = 1'b0;
        line_rand(16, 0);
        idle(3);

        // mixed stress with live reloads and mode flips
        phase = "R7";
        for (int k = 0; k < 60; k++) begin
            for (int i = 0; i < 16; i++) begin
                if (rnd(5) == 0) step(0, 0, 0, 1, rnd(16), rnd(65536), rnd(8192) - 4096);
                step(1, i == 0, (rnd(10) == 0) ? 4095 : rnd(4096),
                     rnd(4) == 0, rnd(16), rnd(65536), rnd(8192) - 4096);
            end
            if (rnd(6) == 0) mode_cal = ~mode_cal;
        end
        mode_cal = 1'b0;
        idle(6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule